// File: doc/BRIEF.md
# MDIO Management Master

This block lets software on a register bus reach the management registers of external Ethernet PHYs over the two-wire MDC/MDIO serial link, using the Clause 22 frame layout. Software picks a PHY and a register through an address register, then launches a transfer. For a write, it stores a 16-bit value into the control-data register. For a read, it raises a command bit. It then polls an indicator register until the transfer is over. Read results land in a status register.

The block makes MDC from the system clock with a programmable divider. It shifts out the frame most significant bit first: preamble, start, opcode, PHY address, register address, turnaround and data. On reads it releases MDIO for the turnaround and the data slots, and samples the PHY on the rising edges of MDC. A reset bit in the configuration register stops any transfer at once.

Register offsets on the 3-bit `reg_addr` are: configuration 0, command 1, address 2, control-data 3, status 4, indicator 5. Reads are combinational from `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `mdio_master`

## Requirements
- R1: After `rst_n` is released, the indicator, status and configuration registers read 0, and MDC and the MDIO output enable are low.
- R2: The address register keeps the PHY address in bits 12:8 and the register address in bits 4:0. All other bits read back as 0.
- R3: A write to the control-data register (offset 3) while idle starts a write frame carrying `reg_wdata[15:0]`. The frame is 32 ones, then 01, opcode 01, PHY address, register address, turnaround 10 and data. All fields go MSB first, and MDIO is driven for all 64 bit slots.
- R4: A read frame starts only when a write to the command register (offset 1) moves bit 0 from 0 to 1. Writing 1 over a stored 1 starts nothing. The read frame carries opcode 10, and the master stops driving MDIO from the first turnaround slot through the last data slot.
- R5: With N in configuration bits 3:0, MDC has a period of 2×(N+1) clocks. Each bit slot starts with MDC low, and MDC stays low while no frame is running.
- R6: Indicator bit 0 (busy) reads 1 from the clock edge that accepts a command for exactly 128×(N+1) cycles. MDC falls for the last time at the end of that window.
- R7: Indicator bit 1 (not-valid) rises with busy when a read starts. It clears on the same edge as busy, when the read data is stored.
- R8: The status register (offset 4) returns the 16 bits sampled on the MDC rising edges of the data slots, first bit as MSB. It changes only when a read completes.
- R9: Writing configuration bit 31 as 1 clears busy, not-valid, MDC and the MDIO output enable on that edge. No frame starts while the bit stays 1, and status keeps its value.
- R10: A write or read command issued while busy is ignored. The running frame continues bit for bit unchanged, and no frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO level driven by the master |
| mdio_oe | output | 1 | MDIO drive enable, high when the master owns the line |

## Verification
The hardest states to reach are a command landing in the middle of a frame and a reset landing partway through a read. Both are timing events that software polling would normally avoid. The frame task can therefore inject any register write at a chosen cycle inside the frame, while the reference model keeps predicting MDC, the drive enable, the data bit and the indicator bits on every clock. A behavioural PHY answers reads on MDC falling edges and records every bit it sees on rising edges. This lets the bench show that an ignored command left the frame unchanged, and that an aborted read left the status register untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // register offsets on the 3-bit register bus
   localparam logic [2:0] A_CFG  = 3'd0;
   localparam logic [2:0] A_CMD  = 3'd1;
   localparam logic [2:0] A_ADDR = 3'd2;
   localparam logic [2:0] A_CTRL = 3'd3;
   localparam logic [2:0] A_STAT = 3'd4;
   localparam logic [2:0] A_IND  = 3'd5;

   // field positions
   localparam int ADDR_PHY_LSB = 8;
   localparam int ADDR_REG_LSB = 0;
   localparam int CMD_RD_BIT   = 0;
   localparam int IND_BUSY_BIT = 0;
   localparam int IND_NV_BIT   = 1;

   // frame constants
   localparam logic [1:0] FR_SOF   = 2'b01;
   localparam logic [1:0] FR_OP_WR = 2'b01;
   localparam logic [1:0] FR_OP_RD = 2'b10;
   localparam logic [1:0] FR_TA_WR = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [SEL_W-1:0] div_sel,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [SEL_W-1:0] div_q;
   logic [SEL_W-1:0] cnt_q;
   logic             at_end;

   assign at_end    = (cnt_q == div_q);
   assign rise_tick = run && !clear && at_end && !mdc;
   assign fall_tick = run && !clear && at_end &&  mdc;

   // divider value is frozen while a frame runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (clear || !run) begin
         div_q <= div_sel;
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (at_end) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc);

   // R5
   mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && !at_end) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int AW      = 5,
   parameter int DW      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          start_wr,
   input  logic          start_rd,
   input  logic [AW-1:0] phy,
   input  logic [AW-1:0] regad,
   input  logic [DW-1:0] wdata,
   input  logic          rise_tick,
   input  logic          fall_tick,
   input  logic          mdio_i,
   output logic          busy,
   output logic          mdio_o,
   output logic          mdio_oe,
   output logic          rd_done,
   output logic [DW-1:0] rd_data
);
   localparam int TA_SLOT   = PRE_LEN + 4 + 2*AW;
   localparam int DATA_SLOT = TA_SLOT + 2;
   localparam int FRAME_W   = DATA_SLOT + DW;
   localparam int CNT_W     = $clog2(FRAME_W + 1);

   initial begin
      if (PRE_LEN < 1 || AW < 1 || DW < 2)
         $error("mdio_frame_eng: bad frame geometry");
   end

   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frame_new;
   logic [CNT_W-1:0]   slot_q;
   logic               rd_q;
   logic               busy_q;
   logic [DW-1:0]      sh_q;
   logic               last;

   assign last = (slot_q == CNT_W'(FRAME_W-1));

   always_comb begin
      frame_new = {{PRE_LEN{1'b1}}, FR_SOF,
                   (start_rd ? FR_OP_RD : FR_OP_WR),
                   phy, regad,
                   (start_rd ? 2'b11 : FR_TA_WR),
                   (start_rd ? {DW{1'b0}} : wdata)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         slot_q  <= '0;
         rd_q    <= 1'b0;
         busy_q  <= 1'b0;
      end else if (abort) begin
         slot_q  <= '0;
         rd_q    <= 1'b0;
         busy_q  <= 1'b0;
      end else if (start_wr || start_rd) begin
         frame_q <= frame_new;
         slot_q  <= '0;
         rd_q    <= start_rd;
         busy_q  <= 1'b1;
      end else if (busy_q && fall_tick) begin
         frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
         slot_q  <= slot_q + 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

   // PHY data is sampled on MDC rising edges within the data slots
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (busy_q && rd_q && rise_tick && (slot_q >= CNT_W'(DATA_SLOT)))
         sh_q <= {sh_q[DW-2:0], mdio_i};
   end

   assign busy    = busy_q;
   assign mdio_o  = frame_q[FRAME_W-1];
   assign mdio_oe = busy_q && !(rd_q && (slot_q >= CNT_W'(TA_SLOT)));
   assign rd_done = busy_q && rd_q && fall_tick && last && !abort;
   assign rd_data = sh_q;

   // R10
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !(start_wr || start_rd));

   // R4
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !mdio_oe) |=> (!mdio_oe || !busy_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int SEL_W   = 4,
   parameter int PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   output logic             mdc,
   input  logic             mdio_i,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int AW      = 5;
   localparam int DW      = 16;
   localparam int RST_BIT = BUS_W - 1;

   initial begin
      if (BUS_W < 16 || SEL_W < 1 || SEL_W >= RST_BIT)
         $error("mdio_master: bad bus or divider width");
   end

   logic [BUS_W-1:0] cfg_q;
   logic             cmd_q;
   logic [AW-1:0]    phy_q;
   logic [AW-1:0]    ra_q;
   logic [DW-1:0]    ctrl_q;
   logic [DW-1:0]    stat_q;
   logic             nv_q;

   logic wr_cfg, wr_cmd, wr_addr, wr_ctrl;
   logic abort, start_wr, start_rd;
   logic busy, rd_done, rise_tick, fall_tick;
   logic [DW-1:0] rd_data;

   assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
   assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
   assign wr_addr = reg_wr && (reg_addr == A_ADDR);
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

   assign abort    = cfg_q[RST_BIT] || (wr_cfg && reg_wdata[RST_BIT]);
   assign start_wr = wr_ctrl && !busy && !abort;
   assign start_rd = wr_cmd && reg_wdata[CMD_RD_BIT] && !cmd_q && !busy && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         cmd_q  <= 1'b0;
         phy_q  <= '0;
         ra_q   <= '0;
         ctrl_q <= '0;
         stat_q <= '0;
         nv_q   <= 1'b0;
      end else begin
         if (wr_cfg)  cfg_q  <= reg_wdata;
         if (wr_cmd)  cmd_q  <= reg_wdata[CMD_RD_BIT];
         if (wr_ctrl) ctrl_q <= reg_wdata[DW-1:0];
         if (wr_addr) begin
            phy_q <= reg_wdata[ADDR_PHY_LSB +: AW];
            ra_q  <= reg_wdata[ADDR_REG_LSB +: AW];
         end
         if (rd_done) stat_q <= rd_data;
         if (abort || rd_done) nv_q <= 1'b0;
         else if (start_rd)    nv_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CFG:  reg_rdata = cfg_q;
         A_CMD:  reg_rdata[CMD_RD_BIT] = cmd_q;
         A_ADDR: begin
            reg_rdata[ADDR_PHY_LSB +: AW] = phy_q;
            reg_rdata[ADDR_REG_LSB +: AW] = ra_q;
         end
         A_CTRL: reg_rdata[DW-1:0] = ctrl_q;
         A_STAT: reg_rdata[DW-1:0] = stat_q;
         A_IND:  begin
            reg_rdata[IND_BUSY_BIT] = busy;
            reg_rdata[IND_NV_BIT]   = nv_q;
         end
         default: reg_rdata = '0;
      endcase
   end

   mdio_clk_gen #(.SEL_W(SEL_W)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .clear     (abort),
      .div_sel   (cfg_q[SEL_W-1:0]),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (abort),
      .start_wr  (start_wr),
      .start_rd  (start_rd),
      .phy       (phy_q),
      .regad     (ra_q),
      .wdata     (reg_wdata[DW-1:0]),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .rd_done   (rd_done),
      .rd_data   (rd_data)
   );

   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && reg_wdata[RST_BIT]) |=> (!busy && !nv_q && !mdio_oe && !mdc));

   // R7
   nv_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_q |-> busy);

   // R8
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |=> $stable(stat_q));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                          A_CTRL = 3'd3, A_STAT = 3'd4, A_IND = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = A_IND;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int vectors = 0;
   int errors  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   // behavioural PHY: records bits on MDC rise, answers reads on MDC fall
   int          rcnt = 0;
   int          base = 0;
   logic [15:0] rd_val = '0;
   logic        cap_bit [0:4095];
   logic        cap_oe  [0:4095];

   always @(posedge mdc) begin
      if (rcnt < 4096) begin
         cap_bit[rcnt] = mdio_o;
         cap_oe[rcnt]  = mdio_oe;
      end
      rcnt = rcnt + 1;
   end

   always @(negedge mdc) begin : phy_drv
      int s;
      s = rcnt - base;
      if (s == 47)                 mdio_i = 1'b0;
      else if (s >= 48 && s < 64)  mdio_i = rd_val[63 - s];
      else                         mdio_i = 1'b1;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = A_IND;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = A_IND;
   endtask

   task automatic idle_watch(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         #1;
         chk(req, "idle indicator", reg_rdata & 32'h3, 32'h0);
         chk(req, "idle mdc", {31'b0, mdc}, 32'h0);
         chk(req, "idle oe", {31'b0, mdio_oe}, 32'h0);
         @(negedge clk);
      end
   endtask

   task automatic run_frame(input bit is_rd, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] data,
                            input int n, input int inj_t, input logic [2:0] inj_a,
                            input logic [31:0] inj_d, input bit inj_abort);
      logic [63:0] fr;
      logic [31:0] st;
      int h, end_t;
      fr = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, ra, 2'b10, data};
      h = n + 1;
      end_t = inj_abort ? inj_t + 1 : 128 * h;
      if (is_rd) rd_val = data;
      base = rcnt;
      if (is_rd) bus_wr(A_CMD, 32'h1);
      else       bus_wr(A_CTRL, {16'h0, data});
      for (int t = 0; t < end_t + 4; t++) begin
         int slot;
         bit bsy, mdc_e, oe_e;
         if (t == inj_t) begin reg_addr = inj_a; reg_wdata = inj_d; reg_wr = 1'b1; end
         if (t == inj_t + 1) begin reg_wr = 1'b0; reg_addr = A_IND; end
         #1;
         slot  = t / (2 * h);
         bsy   = (t < end_t);
         mdc_e = bsy && ((t % (2 * h)) >= h);
         oe_e  = bsy && !(is_rd && slot >= 46);
         chk("R5", "mdc", {31'b0, mdc}, {31'b0, mdc_e});
         chk(is_rd ? "R4" : "R3", "mdio_oe", {31'b0, mdio_oe}, {31'b0, oe_e});
         if (oe_e) chk("R3", "mdio_o", {31'b0, mdio_o}, {31'b0, fr[63 - slot]});
         if (reg_addr == A_IND) begin
            chk("R6", "busy", {31'b0, reg_rdata[0]}, {31'b0, bsy});
            chk("R7", "not-valid", {31'b0, reg_rdata[1]}, {31'b0, bsy && is_rd});
         end
         @(negedge clk);
      end
      if (!inj_abort) begin
         chk("R5", "mdc rising edge count", rcnt - base, 64);
         for (int k = 0; k < 64; k++) begin
            bit oe_k;
            oe_k = !(is_rd && k >= 46);
            chk(is_rd ? "R4" : "R3", "phy saw drive", {31'b0, cap_oe[base + k]}, {31'b0, oe_k});
            if (oe_k) chk("R3", "phy saw bit", {31'b0, cap_bit[base + k]}, {31'b0, fr[63 - k]});
         end
         if (is_rd) begin
            bus_rd(A_STAT, st);
            chk("R8", "status after read", st, {16'h0, data});
         end
      end
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      bus_rd(A_IND, v);  chk("R1", "indicator", v, 32'h0);
      bus_rd(A_STAT, v); chk("R1", "status", v, 32'h0);
      bus_rd(A_CFG, v);  chk("R1", "config", v, 32'h0);
      chk("R1", "mdc", {31'b0, mdc}, 32'h0);
      chk("R1", "oe", {31'b0, mdio_oe}, 32'h0);

      // R2 address field packing
      bus_wr(A_ADDR, 32'hFFFF_FFFF);
      bus_rd(A_ADDR, v); chk("R2", "address all ones", v, 32'h0000_1F1F);
      bus_wr(A_ADDR, 32'h0000_1A0B);
      bus_rd(A_ADDR, v); chk("R2", "address readback", v, 32'h0000_1A0B);

      // R3 write frame, N=1
      bus_wr(A_CFG, 32'h1);
      bus_wr(A_ADDR, 32'h0000_150A);
      run_frame(1'b0, 5'h15, 5'h0A, 16'hA5C3, 1, -10, A_IND, 0, 1'b0);

      // R4 read frame, N=0
      bus_wr(A_CFG, 32'h0);
      bus_wr(A_ADDR, 32'h0000_031F);
      bus_wr(A_CMD, 32'h0);
      run_frame(1'b1, 5'h03, 5'h1F, 16'h8E71, 0, -10, A_IND, 0, 1'b0);

      // R4 no 0-to-1 edge: nothing starts
      bus_wr(A_CMD, 32'h1);
      idle_watch(12, "R4");

      // R10 control-data write mid read is ignored, N=2
      bus_wr(A_CMD, 32'h0);
      bus_wr(A_CFG, 32'h2);
      run_frame(1'b1, 5'h03, 5'h1F, 16'h0001, 2, 100, A_CTRL, 32'h1234, 1'b0);

      // R10 read edge mid write is ignored, no read follows
      bus_wr(A_CMD, 32'h0);
      bus_wr(A_CFG, 32'h1);
      bus_wr(A_ADDR, 32'h0000_1F00);
      run_frame(1'b0, 5'h1F, 5'h00, 16'hFFFF, 1, 30, A_CMD, 32'h1, 1'b0);
      idle_watch(10, "R10");

      // R5 slow divider, N=3, all-zero data
      bus_wr(A_CFG, 32'h3);
      bus_wr(A_ADDR, 32'h0000_0015);
      run_frame(1'b0, 5'h00, 5'h15, 16'h0000, 3, -10, A_IND, 0, 1'b0);

      // R9 abort a read partway through
      bus_wr(A_CMD, 32'h0);
      bus_wr(A_CFG, 32'h1);
      run_frame(1'b1, 5'h00, 5'h15, 16'hBEEF, 1, 70, A_CFG, 32'h8000_0001, 1'b1);
      bus_rd(A_STAT, v); chk("R9", "status kept after abort", v, 32'h0000_0001);
      bus_wr(A_CTRL, 32'h5555);
      bus_wr(A_CMD, 32'h0);
      bus_wr(A_CMD, 32'h1);
      idle_watch(8, "R9");
      bus_wr(A_CFG, 32'h0);
      bus_wr(A_CMD, 32'h0);
      run_frame(1'b1, 5'h00, 5'h15, 16'h7FFE, 0, -10, A_IND, 0, 1'b0);

      report();
      $finish;
   end
endmodule